// File: doc/BRIEF.md
# Compare-Based System Timer Channel

This block is one channel of a system timer. It watches a free-running 64-bit count that arrives from outside and raises an interrupt once that count has reached a programmed compare value. The interrupt is a level, not a pulse. Once the firing condition holds, the line stays high. It drops only when software masks it, disables the channel, or moves the deadline so that the condition no longer holds. This lets an interrupt controller that samples the line see a stable request until the handler has dealt with its cause.

Software reaches the channel through a simple word-wide register port with three registers. The control register holds the enable bit, the mask bit and a read-only status bit. The compare register holds the absolute deadline. The countdown view is a 32-bit signed window onto the same deadline, measured relative to the current count. Writing the countdown view moves the deadline relative to "now". Reading it shows how far away the deadline still is.

Top module: `cmp_timer`

## Requirements
- R1: After reset the enable bit is 0, the mask bit is 0, the compare value is 0 and `irq_o` is 0.
- R2: With enable 1 and mask 0, `irq_o` is 1 after the first clock edge at which the sampled `count_i` is greater than or equal to the compare value. The comparison is equality-inclusive.
- R3: While enable is 1, mask is 0, no register is written and `count_i` stays at or above the compare value, `irq_o` stays 1 on every cycle.
- R4: Control register (address 0) bit 1 is the mask. When the mask is 1, `irq_o` is 0 from the clock edge that writes it, even while the condition holds. Writing the mask back to 0 while the condition holds raises `irq_o` again at that edge.
- R5: Control register bit 0 is the enable. Writing it to 0 drops `irq_o` at the clock edge that takes the write.
- R6: Writing the compare register (address 1, all 64 bits) to a value above the current count drops `irq_o` at that edge. Writing it to a value at or below the count raises `irq_o`.
- R7: A write to the countdown view (address 2) sets compare = count + the sign-extended value of `wdata_i[31:0]`. A positive value drops `irq_o`. A negative value raises it.
- R8: A read of the countdown view returns the low 32 bits of (compare − count), with the upper 32 bits of `rdata_o` zero.
- R9: Control register bit 2 reads as enable AND (count ≥ compare), whatever the mask is. It is 0 while the channel is disabled.
- R10: The comparison is unsigned over all 64 bits. A count with bit 63 clear never reaches a compare value with bit 63 set.
- R11: A write to bit 2 of the control register has no effect. Address 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Free-running system count |
| wr_en_i | input | 1 | Register write strobe, taken at the rising edge |
| addr_i | input | 2 | Register address: 0 control, 1 compare, 2 countdown, 3 unused |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench builds the channel with its default widths: a 64-bit count and compare value and a 32-bit countdown view. Because the count is a bench-driven input rather than an internal counter, the bench can place the count right at the compare value for the equality edge, and at either side of bit 63 for the unsigned case. It can also jump the count so that countdown reads land on chosen negative and positive offsets. Every event that is allowed to drop the line is tested on its own from the firing state: mask, disable, compare rewrite and countdown rewrite.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CT_CNT_W  = 64;
  localparam int CT_VIEW_W = 32;
  localparam int CT_ADDR_W = 2;

  localparam logic [CT_ADDR_W-1:0] CT_A_CTRL = 2'd0;
  localparam logic [CT_ADDR_W-1:0] CT_A_CMP  = 2'd1;
  localparam logic [CT_ADDR_W-1:0] CT_A_CDN  = 2'd2;

  localparam int CT_B_EN   = 0;
  localparam int CT_B_MASK = 1;
  localparam int CT_B_STAT = 2;

  typedef logic [CT_CNT_W-1:0]  cnt_t;
  typedef logic [CT_VIEW_W-1:0] view_t;

  // Unsigned reach test: the deadline has been met or passed.
  function automatic logic ct_reached(input cnt_t cnt, input cnt_t cmp);
    return cnt >= cmp;
  endfunction

  // Deadline from a signed relative offset.
  function automatic cnt_t ct_view_to_cmp(input cnt_t cnt, input view_t v);
    cnt_t ext;
    ext = {{(CT_CNT_W-CT_VIEW_W){v[CT_VIEW_W-1]}}, v};
    return cnt + ext;
  endfunction

  // Remaining distance to the deadline, truncated to the view width.
  function automatic view_t ct_cmp_to_view(input cnt_t cnt, input cnt_t cmp);
    cnt_t diff;
    diff = cmp - cnt;
    return diff[CT_VIEW_W-1:0];
  endfunction
endpackage

// File: rtl/ct_regfile.sv
module ct_regfile
  import ct_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  cnt_t                 count_i,
  input  logic                 wr_en_i,
  input  logic [CT_ADDR_W-1:0] addr_i,
  input  cnt_t                 wdata_i,
  output cnt_t                 rdata_o,
  output logic                 en_q_o,
  output logic                 mask_q_o,
  output cnt_t                 cmp_q_o,
  output logic                 en_d_o,
  output logic                 mask_d_o,
  output cnt_t                 cmp_d_o,
  output logic                 wr_evt_o
);
  logic en_q, mask_q;
  cnt_t cmp_q;
  logic wr_ctrl, wr_cmp, wr_cdn;
  logic en_d, mask_d;
  cnt_t cmp_d;
  logic stat;

  // Decoded write events, brought out for the checks.
  assign wr_ctrl = wr_en_i && (addr_i == CT_A_CTRL);
  assign wr_cmp  = wr_en_i && (addr_i == CT_A_CMP);
  assign wr_cdn  = wr_en_i && (addr_i == CT_A_CDN);

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    cmp_d  = cmp_q;
    if (wr_ctrl) begin
      en_d   = wdata_i[CT_B_EN];
      mask_d = wdata_i[CT_B_MASK];
    end
    if (wr_cmp) cmp_d = wdata_i;
    if (wr_cdn) cmp_d = ct_view_to_cmp(count_i, wdata_i[CT_VIEW_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cmp_q  <= '0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
      cmp_q  <= cmp_d;
    end
  end

  assign stat = en_q && ct_reached(count_i, cmp_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      CT_A_CTRL: begin
        rdata_o[CT_B_EN]   = en_q;
        rdata_o[CT_B_MASK] = mask_q;
        rdata_o[CT_B_STAT] = stat;
      end
      CT_A_CMP: rdata_o = cmp_q;
      CT_A_CDN: rdata_o[CT_VIEW_W-1:0] = ct_cmp_to_view(count_i, cmp_q);
      default:  rdata_o = '0;
    endcase
  end

  assign en_q_o   = en_q;
  assign mask_q_o = mask_q;
  assign cmp_q_o  = cmp_q;
  assign en_d_o   = en_d;
  assign mask_d_o = mask_d;
  assign cmp_d_o  = cmp_d;
  assign wr_evt_o = wr_ctrl || wr_cmp || wr_cdn;

  // R7: a countdown write lands at count plus the signed offset
  a_r7_cdn_sets_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cdn |=> cmp_q == $past(count_i)
                        + {{(CT_CNT_W-CT_VIEW_W){$past(wdata_i[CT_VIEW_W-1])}},
                           $past(wdata_i[CT_VIEW_W-1:0])});

  // R11: writes to the unused address change no state
  a_r11_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd3) |=> $stable(cmp_q) && $stable(en_q) && $stable(mask_q));
endmodule

// File: rtl/ct_irq.sv
module ct_irq
  import ct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t count_i,
  input  logic en_q_i,
  input  logic mask_q_i,
  input  cnt_t cmp_q_i,
  input  logic en_d_i,
  input  logic mask_d_i,
  input  cnt_t cmp_d_i,
  input  logic wr_evt_i,
  output logic irq_o
);
  logic fire_d;
  logic irq_q;

  // Condition from the state that the coming edge will hold.
  assign fire_d = en_d_i && !mask_d_i && ct_reached(count_i, cmp_d_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire_d;
  end

  assign irq_o = irq_q;

  // R4: mask holds the line low
  a_r4_mask_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q_i |-> !irq_q);

  // R5: a disabled channel never drives the line
  a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q_i |-> !irq_q);

  // R3: with no write and the deadline still met, the level persists
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_evt_i && ct_reached(count_i, cmp_q_i)) |=> irq_q);

  // R6: a deadline moved past the count drops the line
  a_r6_rewrite_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt_i && !ct_reached(count_i, cmp_d_i)) |=> !irq_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import ct_pkg::*;
#(
  parameter int CNT_W  = CT_CNT_W,
  parameter int ADDR_W = CT_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic en_q, mask_q, en_d, mask_d, wr_evt;
  cnt_t cmp_q, cmp_d;

  ct_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .en_q_o   (en_q),
    .mask_q_o (mask_q),
    .cmp_q_o  (cmp_q),
    .en_d_o   (en_d),
    .mask_d_o (mask_d),
    .cmp_d_o  (cmp_d),
    .wr_evt_o (wr_evt)
  );

  ct_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count_i),
    .en_q_i   (en_q),
    .mask_q_i (mask_q),
    .cmp_q_i  (cmp_q),
    .en_d_i   (en_d),
    .mask_d_i (mask_d),
    .cmp_d_i  (cmp_d),
    .wr_evt_i (wr_evt),
    .irq_o    (irq_o)
  );

  // R1: nothing fires straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Write taken at the next rising edge; returns at the following falling edge.
  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata; addr = 2'd0;
  endtask

  task automatic set_cnt(input logic [63:0] c);
    cnt = c; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    chk("R1 irq", {63'b0, irq}, 64'd0);
    rd(2'd0, d); chk("R1 ctrl", d, 64'd0);
    rd(2'd1, d); chk("R1 cmp", d, 64'd0);
  endtask

  task automatic t_fire_level;
    wr(2'd1, 64'd100);
    set_cnt(64'd50);
    wr(2'd0, 64'h1);
    chk("R2 below", {63'b0, irq}, 64'd0);
    set_cnt(64'd99);
    chk("R2 one short", {63'b0, irq}, 64'd0);
    set_cnt(64'd100);
    chk("R2 equal", {63'b0, irq}, 64'd1);
    for (int i = 101; i < 106; i++) begin
      set_cnt(64'(i));
      chk("R3 hold", {63'b0, irq}, 64'd1);
    end
  endtask

  task automatic t_mask;
    logic [63:0] d;
    wr(2'd0, 64'h3);
    chk("R4 masked", {63'b0, irq}, 64'd0);
    rd(2'd0, d); chk("R9 status under mask", d, 64'h7);
    set_cnt(64'd110);
    chk("R4 stays masked", {63'b0, irq}, 64'd0);
    wr(2'd0, 64'h1);
    chk("R4 unmask", {63'b0, irq}, 64'd1);
  endtask

  task automatic t_disable;
    logic [63:0] d;
    wr(2'd0, 64'h0);
    chk("R5 disabled", {63'b0, irq}, 64'd0);
    rd(2'd0, d); chk("R9 status off", d, 64'h0);
    wr(2'd0, 64'h4);
    rd(2'd0, d); chk("R11 status not writable", d, 64'h0);
    chk("R11 irq", {63'b0, irq}, 64'd0);
  endtask

  task automatic t_cmp_rewrite;
    set_cnt(64'd200);
    wr(2'd1, 64'd150);
    wr(2'd0, 64'h1);
    chk("R6 firing", {63'b0, irq}, 64'd1);
    wr(2'd1, 64'd300);
    chk("R6 moved above", {63'b0, irq}, 64'd0);
    wr(2'd1, 64'd200);
    chk("R6 moved equal", {63'b0, irq}, 64'd1);
  endtask

  task automatic t_countdown;
    logic [63:0] d;
    set_cnt(64'd1000);
    wr(2'd2, 64'h0000_0000_0000_0005);
    chk("R7 positive drops", {63'b0, irq}, 64'd0);
    rd(2'd1, d); chk("R7 cmp plus", d, 64'd1005);
    rd(2'd2, d); chk("R8 view 5", d, 64'd5);
    set_cnt(64'd1003);
    rd(2'd2, d); chk("R8 view 2", d, 64'd2);
    set_cnt(64'd1000);
    wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFB);
    chk("R7 negative raises", {63'b0, irq}, 64'd1);
    rd(2'd1, d); chk("R7 cmp minus", d, 64'd995);
    rd(2'd2, d); chk("R8 view negative", d, 64'h0000_0000_FFFF_FFFB);
    wr(2'd2, 64'hABCD_0000_0000_0010);
    rd(2'd1, d); chk("R7 upper bits ignored", d, 64'd1016);
  endtask

  task automatic t_unsigned;
    logic [63:0] d;
    wr(2'd1, 64'h8000_0000_0000_0000);
    set_cnt(64'h7FFF_FFFF_FFFF_FFFF);
    chk("R10 below top half", {63'b0, irq}, 64'd0);
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 top", {63'b0, irq}, 64'd1);
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, d); chk("R11 addr3 reads 0", d, 64'd0);
    rd(2'd1, d); chk("R11 cmp untouched", d, 64'h8000_0000_0000_0000);
    chk("R11 irq kept", {63'b0, irq}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fire_level();
    t_mask();
    t_disable();
    t_cmp_rewrite();
    t_countdown();
    t_unsigned();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule